// File: doc/BRIEF.md
# Exception Entry Controller

This block carries out trap and interrupt entry for a 32-bit RISC core. Each cycle it looks at the pending causes and picks the one with the lowest index. Seven of the eight causes come from the core's trap request lines. The eighth, the external interrupt, is let through only while the global interrupt enable is set. When a cause is taken, the block does four things in a single clock edge:

- It computes the handler address, which is a base register plus the cause index times 32.
- It saves the current PC in one of two return-address registers, picked by the cause's class.
- It moves the global enable into a class-specific saved-enable bit.
- It clears the global enable.

On the next cycle it raises a one-cycle redirect strobe together with the new PC.

There are two vector bases, a normal one and a debug one. Debug causes (breakpoint and watchpoint) always use the debug base. All other causes use the debug base while the remap input is high, and the normal base otherwise. Software loads the bases through a small write port. It sets or restores the enable bits through a second write port.

The control is a two-state machine:
- `ST_RUN`: causes are accepted.
- `ST_REDIR`: the redirect is being presented, and all requests are ignored.

It has two transitions:
- `take`: `ST_RUN` to `ST_REDIR` when any effective cause is pending.
- `release`: `ST_REDIR` back to `ST_RUN` unconditionally.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the redirect strobe is low and the following all read zero: the enable bits, both return-address registers, both bases and the cause output.
- R2: Cause indices are fixed as follows: 0 soft reset, 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 external interrupt, 7 system call. Bit i of `trap_req` requests cause i. When several causes are pending, the lowest index is taken and reported on `cause_o`.
- R3: The redirect PC equals the selected base plus the cause index times 32. Its low 5 bits are always zero.
- R4: Causes 1 and 3 use the debug base. All other causes use the debug base when `remap` is 1 and the normal base when `remap` is 0.
- R5: A non-debug cause writes `cur_pc` into `ea_o` and leaves `ba_o` unchanged. A debug cause writes `cur_pc` into `ba_o` and leaves `ea_o` unchanged.
- R6: On a non-debug cause the following happens, with `ie_o` bit 0 = global enable, bit 1 = saved enable for normal traps, bit 2 = saved enable for debug traps:
  - bit 1 becomes 1 if bit 0 was 1, and is otherwise kept;
  - bit 0 becomes 0;
  - bit 2 is kept.
- R7: On a debug cause the following happens, using the same `ie_o` bit layout:
  - bit 2 becomes 1 if bit 0 was 1, and is otherwise kept;
  - bit 0 becomes 0;
  - bit 1 is kept.
- R8: The external interrupt (index 6) is pending only when `irq_req` is 1 and the global enable is 1. `trap_req` bit 6 has no effect.
- R9: A request sampled in `ST_RUN` raises `redirect_o` for exactly one cycle after that edge. Requests sampled while `redirect_o` is high are ignored.
- R10: When `ie_we` is 1, `ie_wdata` is loaded into `ie_o`, unless a cause is taken in the same cycle, in which case the entry update wins.
- R11: When `base_we` is 1, `base_wdata` is written to the debug base if `base_sel` is 1, or to the normal base if `base_sel` is 0. Bits 7:0 of both bases always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 8 | Trap requests, bit i = cause i (bit 6 unused) |
| irq_req | input | 1 | External interrupt request |
| cur_pc | input | 32 | PC of the faulting instruction |
| remap | input | 1 | Send non-debug causes to the debug base |
| ie_we | input | 1 | Enable-bit write strobe |
| ie_wdata | input | 3 | Enable bits to write |
| base_we | input | 1 | Base write strobe |
| base_sel | input | 1 | 0 = normal base, 1 = debug base |
| base_wdata | input | 32 | Base write data |
| redirect_o | output | 1 | One-cycle redirect strobe |
| new_pc_o | output | 32 | Handler address |
| cause_o | output | 3 | Index of the last cause taken |
| ea_o | output | 32 | Return address for non-debug causes |
| ba_o | output | 32 | Return address for debug causes |
| ie_o | output | 3 | Enable bits {debug saved, normal saved, global} |
| nbase_o | output | 32 | Normal vector base |
| dbase_o | output | 32 | Debug vector base |

## Verification
A request driven before rising edge k produces its results together, after edge k: the redirect strobe, the new PC, the cause, the return address and the enable bits. The strobe then falls after edge k+1. The bench drives inputs on falling edges and checks all entry results at the falling edge after edge k. It clears the requests there and checks that the strobe is low one falling edge later. Writes to the enable bits and the bases show at the first falling edge after their rising edge. The bench sweeps all 256 request patterns against every enable value, both interrupt levels and both remap settings. It computes the winner and the vector arithmetically.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int unsigned NCAUSE = 8;
    localparam int unsigned IDXW   = $clog2(NCAUSE);

    typedef enum logic [IDXW-1:0] {
        CAUSE_RESET = 3'd0,
        CAUSE_BREAK = 3'd1,
        CAUSE_IBUS  = 3'd2,
        CAUSE_WATCH = 3'd3,
        CAUSE_DBUS  = 3'd4,
        CAUSE_DIVZ  = 3'd5,
        CAUSE_IRQ   = 3'd6,
        CAUSE_SCALL = 3'd7
    } cause_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_REDIR = 1'b1
    } entry_state_e;

    typedef struct packed {
        logic bie;
        logic eie;
        logic gie;
    } ie_bits_t;

    function automatic logic cause_is_debug(input cause_e c);
        return (c == CAUSE_BREAK) || (c == CAUSE_WATCH);
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
    parameter int unsigned N    = 8,
    parameter int unsigned IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    output logic            any,
    output logic [IDXW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end

    logic [N-1:0] below_mask;
    assign below_mask = (N'(1) << idx) - N'(1);

    // lowest pending index wins: nothing pending below the winner
    assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (((req & below_mask) == '0) && req[idx]));

    assert_none_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !any);

endmodule

// File: rtl/exc_vec.sv
module exc_vec #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned VEC_SHIFT = 5,
    parameter int unsigned IDXW      = 3
) (
    input  logic [XLEN-1:0] nbase,
    input  logic [XLEN-1:0] dbase,
    input  logic            use_dbase,
    input  logic [IDXW-1:0] idx,
    output logic [XLEN-1:0] vec
);

    logic [XLEN-1:0] sel_base;
    logic [XLEN-1:0] offset;

    assign sel_base = use_dbase ? dbase : nbase;
    assign offset   = XLEN'(idx) << VEC_SHIFT;
    assign vec      = sel_base + offset;

endmodule

// File: rtl/exc_ie.sv
module exc_ie
    import exc_entry_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     take,
    input  logic     dbg,
    input  logic     we,
    input  ie_bits_t wdata,
    output ie_bits_t ie_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else if (take) begin
            ie_q.gie <= 1'b0;
            if (dbg) begin
                ie_q.bie <= ie_q.bie | ie_q.gie;
            end else begin
                ie_q.eie <= ie_q.eie | ie_q.gie;
            end
        end else if (we) begin
            ie_q <= wdata;
        end
    end

    assert_normal_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !dbg) |=> (!ie_q.gie
                            && (ie_q.eie == ($past(ie_q.eie) | $past(ie_q.gie)))
                            && (ie_q.bie == $past(ie_q.bie))));

    assert_debug_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && dbg) |=> (!ie_q.gie
                           && (ie_q.bie == ($past(ie_q.bie) | $past(ie_q.gie)))
                           && (ie_q.eie == $past(ie_q.eie))));

    assert_write_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !take) |=> (ie_q == $past(wdata)));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned VEC_SHIFT = 5,
    parameter int unsigned BASE_LSB  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCAUSE-1:0]   trap_req,
    input  logic                irq_req,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                remap,
    input  logic                ie_we,
    input  logic [2:0]          ie_wdata,
    input  logic                base_we,
    input  logic                base_sel,
    input  logic [XLEN-1:0]     base_wdata,
    output logic                redirect_o,
    output logic [XLEN-1:0]     new_pc_o,
    output logic [IDXW-1:0]     cause_o,
    output logic [XLEN-1:0]     ea_o,
    output logic [XLEN-1:0]     ba_o,
    output logic [2:0]          ie_o,
    output logic [XLEN-1:0]     nbase_o,
    output logic [XLEN-1:0]     dbase_o
);

    localparam logic [XLEN-1:0]   BASE_MASK = ~((XLEN'(1) << BASE_LSB) - XLEN'(1));
    localparam logic [NCAUSE-1:0] IRQ_BIT   = NCAUSE'(1) << CAUSE_IRQ;

    entry_state_e state_q, state_d;
    ie_bits_t     ie_q;
    logic [NCAUSE-1:0] eff_req;
    logic              any_pend;
    logic [IDXW-1:0]   win_idx;
    logic              win_dbg;
    logic              take;
    logic [XLEN-1:0]   vec;
    logic [XLEN-1:0]   nbase_q, dbase_q, ea_q, ba_q, pc_q;
    logic [IDXW-1:0]   cause_q;

    // interrupt line replaces request bit 6, gated by global enable
    assign eff_req = (trap_req & ~IRQ_BIT)
                   | (NCAUSE'(irq_req & ie_q.gie) << CAUSE_IRQ);

    exc_prio #(.N(NCAUSE), .IDXW(IDXW)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (eff_req),
        .any   (any_pend),
        .idx   (win_idx)
    );

    assign win_dbg = cause_is_debug(cause_e'(win_idx));
    assign take    = (state_q == ST_RUN) && any_pend;

    exc_vec #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .IDXW(IDXW)) u_vec (
        .nbase     (nbase_q),
        .dbase     (dbase_q),
        .use_dbase (win_dbg || remap),
        .idx       (win_idx),
        .vec       (vec)
    );

    exc_ie u_ie (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .dbg   (win_dbg),
        .we    (ie_we),
        .wdata (ie_bits_t'(ie_wdata)),
        .ie_q  (ie_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions: take (RUN->REDIR), release (REDIR->RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (any_pend) state_d = ST_REDIR;
            ST_REDIR: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // entry results and base registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            cause_q <= '0;
            ea_q    <= '0;
            ba_q    <= '0;
            nbase_q <= '0;
            dbase_q <= '0;
        end else begin
            if (take) begin
                pc_q    <= vec;
                cause_q <= win_idx;
                if (win_dbg) ba_q <= cur_pc;
                else         ea_q <= cur_pc;
            end
            if (base_we) begin
                if (base_sel) dbase_q <= base_wdata & BASE_MASK;
                else          nbase_q <= base_wdata & BASE_MASK;
            end
        end
    end

    assign redirect_o = (state_q == ST_REDIR);
    assign new_pc_o   = pc_q;
    assign cause_o    = cause_q;
    assign ea_o       = ea_q;
    assign ba_o       = ba_q;
    assign ie_o       = ie_q;
    assign nbase_o    = nbase_q;
    assign dbase_o    = dbase_q;

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    assert_take_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_o && ((trap_req & ~IRQ_BIT) != '0)) |=> redirect_o);

    assert_vec_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (new_pc_o[VEC_SHIFT-1:0] == '0));

    assert_ea_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !win_dbg) |=> ((ea_o == $past(cur_pc)) && $stable(ba_o)));

    assert_ba_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_dbg) |=> ((ba_o == $past(cur_pc)) && $stable(ea_o)));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && $rose(redirect_o) && (cause_o == CAUSE_IRQ))
            |-> $past(irq_req && ie_o[0]));

    assert_bases_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((nbase_o[BASE_LSB-1:0] == '0) && (dbase_o[BASE_LSB-1:0] == '0)));

endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  trap_req = '0;
    logic        irq_req = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        remap = 1'b0;
    logic        ie_we = 1'b0;
    logic [2:0]  ie_wdata = '0;
    logic        base_we = 1'b0;
    logic        base_sel = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        redirect_o;
    logic [31:0] new_pc_o, ea_o, ba_o, nbase_o, dbase_o;
    logic [2:0]  cause_o, ie_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_nbase, m_dbase, m_ea, m_ba;
    logic [2:0]  m_ie;

    always #10 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
        .cur_pc(cur_pc), .remap(remap), .ie_we(ie_we), .ie_wdata(ie_wdata),
        .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
        .redirect_o(redirect_o), .new_pc_o(new_pc_o), .cause_o(cause_o),
        .ea_o(ea_o), .ba_o(ba_o), .ie_o(ie_o), .nbase_o(nbase_o), .dbase_o(dbase_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int winner(input logic [7:0] t, input logic irq, input logic gie);
        logic [7:0] e;
        e = t;
        e[6] = irq & gie;
        for (int i = 0; i < 8; i++) if (e[i]) return i;
        return -1;
    endfunction

    task automatic write_ie(input logic [2:0] v);
        ie_we = 1'b1; ie_wdata = v;
        @(posedge clk); @(negedge clk);
        ie_we = 1'b0;
        m_ie = v;
    endtask

    task automatic write_base(input logic sel, input logic [31:0] v);
        base_we = 1'b1; base_sel = sel; base_wdata = v;
        @(posedge clk); @(negedge clk);
        base_we = 1'b0;
        if (sel) m_dbase = v & 32'hFFFF_FF00;
        else     m_nbase = v & 32'hFFFF_FF00;
        chk("R11 base", sel ? dbase_o : nbase_o, sel ? m_dbase : m_nbase);
    endtask

    // one entry attempt; all results checked at the falling edge after the take edge
    task automatic run_case(input logic [7:0] t, input logic irq, input logic rm,
                            input logic [2:0] ie0, input logic [31:0] pc);
        int w;
        bit dbg;
        logic [31:0] base;
        write_ie(ie0);
        trap_req = t; irq_req = irq; remap = rm; cur_pc = pc;
        @(posedge clk); @(negedge clk);
        trap_req = '0; irq_req = 1'b0;
        w = winner(t, irq, ie0[0]);
        if (w < 0) begin
            chk("R8 no entry", {31'd0, redirect_o}, 32'd0);
            chk("R5 ea held", ea_o, m_ea);
            chk("R5 ba held", ba_o, m_ba);
            chk("R8 ie held", {29'd0, ie_o}, {29'd0, m_ie});
        end else begin
            dbg  = (w == 1) || (w == 3);
            base = (dbg || rm) ? m_dbase : m_nbase;
            if (dbg) begin
                m_ba = pc;
                if (m_ie[0]) m_ie[2] = 1'b1;
            end else begin
                m_ea = pc;
                if (m_ie[0]) m_ie[1] = 1'b1;
            end
            m_ie[0] = 1'b0;
            chk("R9 strobe", {31'd0, redirect_o}, 32'd1);
            chk("R2 cause", {29'd0, cause_o}, w);
            chk("R3 R4 vector", new_pc_o, base + w * 32);
            chk("R5 ea", ea_o, m_ea);
            chk("R5 ba", ba_o, m_ba);
            chk(dbg ? "R7 ie" : "R6 ie", {29'd0, ie_o}, {29'd0, m_ie});
        end
        @(posedge clk); @(negedge clk);
        chk("R9 strobe low", {31'd0, redirect_o}, 32'd0);
    endtask

    initial begin
        m_nbase = '0; m_dbase = '0; m_ea = '0; m_ba = '0; m_ie = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 redirect", {31'd0, redirect_o}, 32'd0);
        chk("R1 ie", {29'd0, ie_o}, 32'd0);
        chk("R1 ea", ea_o, 32'd0);
        chk("R1 ba", ba_o, 32'd0);
        chk("R1 nbase", nbase_o, 32'd0);
        chk("R1 dbase", dbase_o, 32'd0);
        chk("R1 cause", {29'd0, cause_o}, 32'd0);

        write_base(1'b0, 32'h1234_56AB);
        write_base(1'b1, 32'hFFFF_FF77);

        // R2 R4 R6 R7 R8: full sweep of request patterns
        for (int rm = 0; rm < 2; rm++)
            for (int ie0 = 0; ie0 < 8; ie0++)
                for (int irq = 0; irq < 2; irq++)
                    for (int t = 0; t < 256; t++)
                        run_case(8'(t), irq[0], rm[0], 3'(ie0),
                                 32'hA000_0000 ^ (t << 8) ^ (ie0 << 2) ^ (irq << 20) ^ (rm << 24));

        // R11 new bases then single causes
        write_base(1'b0, 32'h0000_10FF);
        write_base(1'b1, 32'h8000_2001);
        for (int i = 0; i < 8; i++) begin
            run_case(8'(1 << i), 1'b1, 1'b0, 3'b001, 32'h0000_4000 + i * 4);
            run_case(8'(1 << i), 1'b1, 1'b1, 3'b001, 32'h0000_5000 + i * 4);
        end

        // R10 entry wins over a same-cycle enable write
        write_ie(3'b001);
        trap_req = 8'h20; cur_pc = 32'h0000_0ABC; ie_we = 1'b1; ie_wdata = 3'b110;
        @(posedge clk); @(negedge clk);
        trap_req = '0; ie_we = 1'b0;
        m_ea = 32'h0000_0ABC; m_ie = 3'b010;
        chk("R10 entry beats write", {29'd0, ie_o}, {29'd0, m_ie});
        @(posedge clk); @(negedge clk);

        // R9 request held through the redirect cycle is ignored there
        trap_req = 8'h80; cur_pc = 32'h0000_1110;
        @(posedge clk); @(negedge clk);
        chk("R9 first take", ea_o, 32'h0000_1110);
        cur_pc = 32'h0000_2220;
        @(posedge clk); @(negedge clk);
        chk("R9 ignored in redirect", ea_o, 32'h0000_1110);
        chk("R9 strobe dropped", {31'd0, redirect_o}, 32'd0);
        @(posedge clk); @(negedge clk);
        trap_req = '0;
        chk("R9 retaken", ea_o, 32'h0000_2220);
        chk("R9 strobe again", {31'd0, redirect_o}, 32'd1);
        @(posedge clk); @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule